// File: doc/BRIEF.md
# Carrier-Switching Data Signal Modulator

This block keys a data stream onto a carrier. The data stream (the modulator level) picks one of two carriers. While it is high, the "mark" carrier is passed to the output. While it is low, the "space" carrier is passed. Each carrier is chosen from a vector of candidate sources by a 4-bit select code. The modulator is chosen the same way from its own candidates, or from a bit that software writes.

Each carrier path can be inverted. Each path can also be made to wait for its carrier's next rising edge before it takes over, so that no shortened first pulse appears. The combination gives three kinds of keying:
- frequency-shift keying: two carriers of different rates;
- on-off keying: the space carrier tied low;
- phase-shift keying: one carrier used twice, with opposite polarities.

All candidate sources are treated as asynchronous. They pass through a two-flop synchroniser before selection. Configuration arrives on plain input ports and takes effect at the next clock edge. The result is registered, can be inverted, is forced to its idle level when the block is disabled, and is held low when driving is switched off.

Top module: `carrier_keyer`

## Requirements
- R1: Carrier select codes (mark and space alike):
  - 0 gives constant low.
  - 1 to 7 pick `car_src[code-1]`, where bit 0 is external input 1, bit 1 is external input 2, bit 2 is the reference clock, and bits 3 to 6 are four capture/compare outputs.
  - 8 to 15 give constant low.
- R2: Modulator select codes:
  - 0 picks `soft_bit`.
  - 1 to 10 pick `mod_src[code-1]`, where bit 0 is the external pin, bits 1 to 4 are capture/compare outputs, bits 5 and 6 are comparators, bits 7 and 8 are serial data outputs, and bit 9 is the UART transmit line.
  - 11 to 15 give constant low.
- R3: With sync off, `keyed_out` equals the mark carrier while the modulator is high and the space carrier while it is low. A change on any source pin or on `soft_bit` reaches `keyed_out` after three rising clock edges.
- R4: `mark_inv` and `space_inv` invert their own carrier before mixing.
- R5: With a path's sync on, that path contributes nothing after the modulator turns to it until its (polarity-applied) carrier shows a rising edge. From then on it passes the carrier until the modulator leaves it, and it stops at once when the modulator leaves.
- R6: `out_inv` inverts the mixed result.
- R7: With `enable` low and `drive_en` high, `keyed_out` equals `out_inv` one edge later, and all sync state is cleared.
- R8: With `drive_en` low, `keyed_out` is 0 one edge later.
- R9: A synchronous reset drives `keyed_out` to 0.
- R10: A change on a select, polarity, enable or drive control shows at `keyed_out` after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| car_src | input | 7 | Candidate carrier sources (asynchronous) |
| mod_src | input | 10 | Candidate modulator sources (asynchronous) |
| soft_bit | input | 1 | Software-written modulator bit |
| mark_sel | input | 4 | Carrier select used while the modulator is high |
| space_sel | input | 4 | Carrier select used while the modulator is low |
| mod_sel | input | 4 | Modulator select |
| mark_inv | input | 1 | Invert the mark carrier |
| space_inv | input | 1 | Invert the space carrier |
| mark_sync | input | 1 | Mark path waits for its carrier's rising edge |
| space_sync | input | 1 | Space path waits for its carrier's rising edge |
| out_inv | input | 1 | Invert the modulated output |
| enable | input | 1 | Module enable |
| drive_en | input | 1 | Output drive enable |
| keyed_out | output | 1 | Registered modulated output |

## Verification
A stuck or stale path gate is the main risk. It shows as a whole carrier pulse that is missing or added at a modulator transition, or as a pulse that is cut short. Either fault appears at `keyed_out` within three edges of the transition. The sync state left over from a disable period would show on the first edge after re-enabling, as a carrier that is already high being passed or held back wrongly. A fault in the synchroniser depth or in a select decode shifts or replaces the output waveform. Comparing every cycle against a reference model catches it within one carrier period.

// File: rtl/ck_pkg.sv
package ck_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t sel;
    logic inv;
    logic sync;
  } path_cfg_t;
endpackage

// File: rtl/ck_sync2.sv
module ck_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/ck_mod_pick.sv
module ck_mod_pick #(
  parameter int SRCS = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  ck_pkg::sel_t  code,
  input  logic [SRCS:0] cand,
  output logic          level
);
  always_comb begin
    level = 1'b0;
    for (int i = 0; i <= SRCS; i++) begin
      if (int'(code) == i) level = cand[i];
    end
  end

  // R2
  mod_unused_low_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(code) > SRCS) |-> !level);
endmodule

// File: rtl/ck_carrier_path.sv
module ck_carrier_path #(
  parameter int SRCS    = 7,
  parameter bit ON_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mod_level,
  input  ck_pkg::path_cfg_t cfg,
  input  logic [SRCS-1:0]   src,
  output logic              contrib
);
  logic car_raw;
  logic car_pol;
  logic car_d_q;
  logic gate_q;
  logic want;
  logic gate_eff;

  always_comb begin
    car_raw = 1'b0;
    for (int i = 0; i < SRCS; i++) begin
      if (int'(cfg.sel) == i + 1) car_raw = src[i];
    end
  end

  assign car_pol = car_raw ^ cfg.inv;
  assign want    = ON_HIGH ? mod_level : !mod_level;

  generate
    if (ON_HIGH) begin : g_mark
      assign gate_eff = cfg.sync ? (want & (gate_q | (car_pol & !car_d_q))) : want;
    end else begin : g_space
      assign gate_eff = cfg.sync ? (want & (gate_q | (car_pol & !car_d_q))) : want;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      gate_q  <= 1'b0;
      car_d_q <= 1'b0;
    end else begin
      gate_q  <= gate_eff;
      car_d_q <= car_pol;
    end
  end

  assign contrib = enable & gate_eff & car_pol;

  // R1
  car_unused_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.sel == '0 || int'(cfg.sel) > SRCS) |-> !car_raw);
  // R5
  gate_leave_chk: assert property (@(posedge clk) disable iff (rst)
    !want |-> !contrib);
  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && cfg.sync && gate_q && want) |-> (contrib == car_pol));
  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!gate_q && !car_d_q));
endmodule

// File: rtl/carrier_keyer.sv
module carrier_keyer #(
  parameter int CAR_SRCS = 7,
  parameter int MOD_SRCS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CAR_SRCS-1:0] car_src,
  input  logic [MOD_SRCS-1:0] mod_src,
  input  logic                soft_bit,
  input  logic [3:0]          mark_sel,
  input  logic [3:0]          space_sel,
  input  logic [3:0]          mod_sel,
  input  logic                mark_inv,
  input  logic                space_inv,
  input  logic                mark_sync,
  input  logic                space_sync,
  input  logic                out_inv,
  input  logic                enable,
  input  logic                drive_en,
  output logic                keyed_out
);
  import ck_pkg::*;

  localparam int MOD_VEC_W = MOD_SRCS + 1;

  logic [CAR_SRCS-1:0]  car_s;
  logic [MOD_VEC_W-1:0] mod_s;
  logic                 mod_level;
  logic                 mark_c;
  logic                 space_c;
  logic                 mix;
  logic                 out_q;
  path_cfg_t            mark_cfg;
  path_cfg_t            space_cfg;

  assign mark_cfg  = '{sel: mark_sel,  inv: mark_inv,  sync: mark_sync};
  assign space_cfg = '{sel: space_sel, inv: space_inv, sync: space_sync};

  ck_sync2 #(.W(CAR_SRCS)) u_car_sync (
    .clk(clk), .rst(rst), .d(car_src), .q(car_s)
  );

  ck_sync2 #(.W(MOD_VEC_W)) u_mod_sync (
    .clk(clk), .rst(rst), .d({mod_src, soft_bit}), .q(mod_s)
  );

  ck_mod_pick #(.SRCS(MOD_SRCS)) u_mod_pick (
    .clk(clk), .rst(rst), .code(mod_sel), .cand(mod_s), .level(mod_level)
  );

  ck_carrier_path #(.SRCS(CAR_SRCS), .ON_HIGH(1'b1)) u_mark (
    .clk(clk), .rst(rst), .enable(enable), .mod_level(mod_level),
    .cfg(mark_cfg), .src(car_s), .contrib(mark_c)
  );

  ck_carrier_path #(.SRCS(CAR_SRCS), .ON_HIGH(1'b0)) u_space (
    .clk(clk), .rst(rst), .enable(enable), .mod_level(mod_level),
    .cfg(space_cfg), .src(car_s), .contrib(space_c)
  );

  assign mix = mark_c | space_c;

  always_ff @(posedge clk) begin
    if (rst)            out_q <= 1'b0;
    else if (!drive_en) out_q <= 1'b0;
    else if (!enable)   out_q <= out_inv;
    else                out_q <= mix ^ out_inv;
  end

  assign keyed_out = out_q;

  // R8
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> !keyed_out);
  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !enable) |=> (keyed_out == $past(out_inv)));
  // R3
  one_path_chk: assert property (@(posedge clk) disable iff (rst)
    !(mark_c && space_c));
  // R6
  mix_out_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en && enable) |=> (keyed_out == ($past(mix) ^ $past(out_inv))));
endmodule

// File: tb/carrier_keyer_test.sv
`timescale 1ns/1ps
module carrier_keyer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] car_src;
  logic [9:0] mod_src;
  logic       soft_bit;
  logic [3:0] mark_sel = 4'd0, space_sel = 4'd0, mod_sel = 4'd0;
  logic       mark_inv = 0, space_inv = 0, mark_sync = 0, space_sync = 0;
  logic       out_inv = 0, enable = 0, drive_en = 0;
  logic       keyed_out;

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  logic manual = 0, ext1_man = 0, soft_force = 0, soft_val = 0;
  logic [6:0] auto_car;
  logic [9:0] auto_mod;

  always #4 clk = ~clk;

  carrier_keyer uut (
    .clk(clk), .rst(rst), .car_src(car_src), .mod_src(mod_src),
    .soft_bit(soft_bit), .mark_sel(mark_sel), .space_sel(space_sel),
    .mod_sel(mod_sel), .mark_inv(mark_inv), .space_inv(space_inv),
    .mark_sync(mark_sync), .space_sync(space_sync), .out_inv(out_inv),
    .enable(enable), .drive_en(drive_en), .keyed_out(keyed_out)
  );

  // stimulus waveforms, changed on falling edges
  always @(negedge clk) cyc <= cyc + 1;
  always_comb begin
    for (int i = 0; i < 7; i++) auto_car[i] = ((cyc / (i + 2)) % 2) == 1;
    for (int i = 0; i < 10; i++) auto_mod[i] = ((cyc / (20 + 6 * i)) % 2) == 1;
  end
  assign car_src  = manual ? {6'b0, ext1_man} : auto_car;
  assign mod_src  = auto_mod;
  assign soft_bit = soft_force ? soft_val : ((cyc / 17) % 2 == 1);

  // cycle-accurate reference built from the requirements
  logic [6:0]  m_c1, m_c2;
  logic [10:0] m_m1, m_m2;
  logic m_gh, m_gl, m_dh, m_dl, m_out;

  function automatic logic pick_car(input logic [3:0] c, input logic [6:0] v);
    return (c >= 1 && c <= 7) ? v[c - 1] : 1'b0;
  endfunction
  function automatic logic pick_mod(input logic [3:0] c, input logic [10:0] v);
    return (c <= 10) ? v[c] : 1'b0;
  endfunction

  always @(posedge clk) begin
    logic ch, cl, md, eh, el;
    if (rst) begin
      m_c1 <= '0; m_c2 <= '0; m_m1 <= '0; m_m2 <= '0;
      m_gh <= 0; m_gl <= 0; m_dh <= 0; m_dl <= 0; m_out <= 0;
    end else begin
      m_c1 <= car_src; m_c2 <= m_c1;
      m_m1 <= {mod_src, soft_bit}; m_m2 <= m_m1;
      ch = pick_car(mark_sel, m_c2) ^ mark_inv;
      cl = pick_car(space_sel, m_c2) ^ space_inv;
      md = pick_mod(mod_sel, m_m2);
      eh = md  && (!mark_sync  || m_gh || (ch && !m_dh));
      el = !md && (!space_sync || m_gl || (cl && !m_dl));
      if (!enable) begin
        m_gh <= 0; m_gl <= 0; m_dh <= 0; m_dl <= 0;
      end else begin
        m_gh <= eh; m_gl <= el; m_dh <= ch; m_dl <= cl;
      end
      if (!drive_en)    m_out <= 0;
      else if (!enable) m_out <= out_inv;
      else              m_out <= ((eh && ch) || (el && cl)) ^ out_inv;
    end
  end

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: keyed_out=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0] hs, ls, ms;
    logic hi, li, hy, ly, oi;
  } row_t;

  localparam int NROWS = 10;
  // hs, ls, ms, mark_inv, space_inv, mark_sync, space_sync, out_inv
  localparam row_t ROWS [NROWS] = '{
    '{4'd1, 4'd2,  4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 FSK raw
    '{4'd1, 4'd2,  4'd1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 FSK synced
    '{4'd3, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 OOK raw
    '{4'd5, 4'd0,  4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 OOK synced
    '{4'd1, 4'd1,  4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 PSK raw
    '{4'd6, 4'd6,  4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 PSK synced
    '{4'd8, 4'd4,  4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 reserved mark
    '{4'd7, 4'd12, 4'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 unused mod code
    '{4'd2, 4'd7,  4'd7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 inverted out
    '{4'd7, 4'd4,  4'd9,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R2 serial source
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: keyed_out=%0b expected %0b", keyed_out, 1'b0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    // R9 reset state
    check(keyed_out == 1'b0, "R9 reset", keyed_out, 1'b0);
    rst = 0; enable = 1; drive_en = 1;

    for (int r = 0; r < NROWS; r++) begin
      int bad;
      logic a, e;
      mark_sel = ROWS[r].hs; space_sel = ROWS[r].ls; mod_sel = ROWS[r].ms;
      mark_inv = ROWS[r].hi; space_inv = ROWS[r].li;
      mark_sync = ROWS[r].hy; space_sync = ROWS[r].ly; out_inv = ROWS[r].oi;
      bad = 0; a = 0; e = 0;
      for (int k = 0; k < 160; k++) begin
        edges(1);
        if (keyed_out !== m_out) begin
          if (bad == 0) begin a = keyed_out; e = m_out; end
          bad++;
        end
      end
      check(bad == 0, $sformatf("R3 model row %0d (R1 R2 R4 R5 R6)", r), a, e);
    end

    // R5 sync: a carrier already high must wait for a fresh rising edge
    manual = 1; ext1_man = 1; soft_force = 1; soft_val = 0;
    mark_sel = 1; space_sel = 0; mod_sel = 0;
    mark_inv = 0; space_inv = 0; mark_sync = 1; space_sync = 0; out_inv = 0;
    edges(6);
    soft_val = 1;
    edges(8);
    check(keyed_out == 1'b0, "R5 no edge yet", keyed_out, 1'b0);
    ext1_man = 0;
    edges(4);
    ext1_man = 1;
    edges(2);
    check(keyed_out == 1'b0, "R5 edge latency 2", keyed_out, 1'b0);
    edges(1);
    check(keyed_out == 1'b1, "R5 edge passed", keyed_out, 1'b1);

    // R3 raw path: modulator rise shows after three edges
    mark_sync = 0; soft_val = 0;
    edges(6);
    check(keyed_out == 1'b0, "R3 mod low", keyed_out, 1'b0);
    soft_val = 1;
    edges(2);
    check(keyed_out == 1'b0, "R3 latency 2", keyed_out, 1'b0);
    edges(1);
    check(keyed_out == 1'b1, "R3 latency 3", keyed_out, 1'b1);

    // R10 and R1: select change visible after one edge
    mark_sel = 0;
    edges(1);
    check(keyed_out == 1'b0, "R1 code 0 low", keyed_out, 1'b0);
    mark_sel = 1;
    edges(1);
    check(keyed_out == 1'b1, "R10 select step", keyed_out, 1'b1);
    mark_sel = 8;
    edges(1);
    check(keyed_out == 1'b0, "R1 code 8 low", keyed_out, 1'b0);
    mark_sel = 1; mark_inv = 1;
    edges(1);
    check(keyed_out == 1'b0, "R4 mark invert", keyed_out, 1'b0);
    mark_inv = 0; out_inv = 1;
    edges(1);
    check(keyed_out == 1'b0, "R6 out invert", keyed_out, 1'b0);

    // R7 disable forces the idle level
    enable = 0;
    edges(1);
    check(keyed_out == 1'b1, "R7 idle inv", keyed_out, 1'b1);
    out_inv = 0;
    edges(1);
    check(keyed_out == 1'b0, "R7 idle plain", keyed_out, 1'b0);
    // R7 sync state cleared: re-enable with carrier already high
    mark_sync = 1; enable = 1;
    edges(1);
    check(keyed_out == 1'b1, "R7 cleared edge state", keyed_out, 1'b1);

    // R8 drive off
    drive_en = 0; out_inv = 1;
    edges(1);
    check(keyed_out == 1'b0, "R8 drive off", keyed_out, 1'b0);

    // R9 reset mid-run
    drive_en = 1; enable = 0;
    edges(1);
    rst = 1;
    edges(1);
    check(keyed_out == 1'b0, "R9 reset again", keyed_out, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule